// File: doc/BRIEF.md
# Packet preamble and header framer

This block is the transmit-side framing engine of a spread-spectrum baseband. A start pulse opens a frame. The block then emits one serial bit per clock, in three parts. The first part is a run of one-bits used for receiver synchronisation. The second is a header whose field set is chosen by a 2-bit protocol mode. The third is a number of payload bits taken from an upstream source over a valid/ready handshake. The number of payload bits is the programmed length value.

Each output bit carries a modulation flag. Sync and header bits are always marked as differential BPSK. Payload bits are marked with the selected data modulation, BPSK or QPSK. The header's CRC-16 is computed on the fly as the header leaves, and it is held on a status output for readback.

An external-framing option skips the internal sync run and the header, so the frame goes straight to payload. All settings are captured when a frame starts.

Top module: `hdr_framer`

## Requirements
- R1: While reset is asserted, and after it is released, `busy`, `tx_valid` and `pl_ready` are 0 and `crc_status` is 0x0000.
- R2: A frame with internal framing starts with `cfg_pre_len` bits of value 1, and each of these bits has `tx_qpsk`=0. A count of 0 sends no sync bits.
- R3: The header fields are sent in the order SFD(16), signal(8), service(8), length(16), CRC(16), and only the fields the mode selects are sent. Mode 0 sends SFD. Mode 1 sends SFD and CRC. Mode 2 sends SFD, length and CRC. Mode 3 sends all five fields. No bits are emitted after the frame ends.
- R4: Every header field is sent least-significant bit first. The length field carries `cfg_length`.
- R5: The CRC register is preset to 0xFFFF. For each bit b, taken in transmit order over the signal, service and length fields, the register updates as fb=crc[15]^b, crc={crc[14:0],0} XOR (fb ? 0x1021 : 0). The final value is sent LSB first. Mode 0 sends no CRC, and in mode 1 the CRC value is 0xFFFF.
- R6: The signal field carries `cfg_sig_qpsk` when `cfg_qpsk`=1 and `cfg_sig_bpsk` when `cfg_qpsk`=0.
- R7: `tx_qpsk` is 0 for every sync and header bit. For payload bits it equals `cfg_qpsk` as captured at start.
- R8: Exactly `cfg_length` payload bits follow the header. Each one is the `pl_data` value accepted on a cycle with `pl_valid`=1 and `pl_ready`=1, and they leave in acceptance order. `pl_ready` is high only during the payload phase. A length of 0 ends the frame after the header.
- R9: `busy` is 1 from the cycle after an accepted start until the frame ends. A start pulse while `busy`=1 is ignored.
- R10: When a header containing a CRC completes, `crc_status` takes that CRC value. Frames in mode 0 or with external framing leave `crc_status` unchanged.
- R11: With `cfg_ext_pre`=1 there are no sync or header bits, and the frame consists only of the `cfg_length` payload bits.
- R12: All configuration inputs are sampled on the start cycle. Changing them during a frame has no effect on that frame.
- R13: A `cfg_pre_len` above 256 is treated as 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame start pulse |
| cfg_mode | input | 2 | Header protocol mode 0..3 |
| cfg_ext_pre | input | 1 | 1 = skip internal sync and header |
| cfg_qpsk | input | 1 | Payload modulation, 1 = QPSK |
| cfg_pre_len | input | PRE_W (9) | Sync bit count, clamped to PRE_MAX |
| cfg_sfd | input | 16 | SFD field value |
| cfg_sig_bpsk | input | 8 | Signal code for BPSK payload |
| cfg_sig_qpsk | input | 8 | Signal code for QPSK payload |
| cfg_service | input | 8 | Service field value |
| cfg_length | input | 16 | Payload bit count, sent in length field |
| pl_valid | input | 1 | Payload bit valid |
| pl_data | input | 1 | Payload bit |
| pl_ready | output | 1 | Payload bit accepted this cycle when valid |
| busy | output | 1 | Frame in progress |
| tx_valid | output | 1 | Output bit valid |
| tx_bit | output | 1 | Serial output bit |
| tx_qpsk | output | 1 | Modulation flag of the output bit |
| crc_status | output | 16 | CRC of the last header that carried one |

## Verification
A wrong field index or bit counter in the sequencer shows at once in `tx_bit`. It is visible on the first misplaced header bit, one cycle after the sequencer state that produced it, and the stream-by-stream comparison catches it. A corrupted running CRC stays hidden until the CRC field is sent. It then shows within 16 bits, and `crc_status` confirms it once the header ends. Errors in the payload count or in the captured settings appear as missing or extra bits, or as a wrong modulation flag, at the end of the frame.

// File: rtl/hdr_framer_pkg.sv
package hdr_framer_pkg;

  localparam int SFD_W = 16;
  localparam int SIG_W = 8;
  localparam int SVC_W = 8;
  localparam int LEN_W = 16;
  localparam int CRC_W = 16;

  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_HDR,
    ST_PAY
  } state_e;

  typedef enum logic [2:0] {
    FLD_SFD,
    FLD_SIG,
    FLD_SVC,
    FLD_LEN,
    FLD_CRC,
    FLD_NONE
  } fld_e;

  // Bit width of each header field.
  function automatic int unsigned fld_len(fld_e f);
    case (f)
      FLD_SFD: return SFD_W;
      FLD_SIG: return SIG_W;
      FLD_SVC: return SVC_W;
      FLD_LEN: return LEN_W;
      FLD_CRC: return CRC_W;
      default: return 1;
    endcase
  endfunction

  // Field that follows f under the given protocol mode.
  function automatic fld_e fld_next(logic [1:0] mode, fld_e f);
    case (f)
      FLD_SFD: begin
        case (mode)
          2'd0:    return FLD_NONE;
          2'd1:    return FLD_CRC;
          2'd2:    return FLD_LEN;
          default: return FLD_SIG;
        endcase
      end
      FLD_SIG: return FLD_SVC;
      FLD_SVC: return FLD_LEN;
      FLD_LEN: return FLD_CRC;
      default: return FLD_NONE;
    endcase
  endfunction

  // One serial step of the CRC-16 register.
  function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] c, logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

endpackage

// File: rtl/hdr_framer_cfg.sv
module hdr_framer_cfg
  import hdr_framer_pkg::*;
#(
  parameter int PRE_MAX = 256,
  parameter int PRE_W   = $clog2(PRE_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       in_mode,
  input  logic             in_ext,
  input  logic             in_qpsk,
  input  logic [PRE_W-1:0] in_pre,
  input  logic [SFD_W-1:0] in_sfd,
  input  logic [SIG_W-1:0] in_sig_b,
  input  logic [SIG_W-1:0] in_sig_q,
  input  logic [SVC_W-1:0] in_svc,
  input  logic [LEN_W-1:0] in_len,
  output logic [1:0]       eff_mode,
  output logic             eff_ext,
  output logic             eff_qpsk,
  output logic [PRE_W-1:0] eff_pre,
  output logic [SFD_W-1:0] eff_sfd,
  output logic [SIG_W-1:0] eff_sig,
  output logic [SVC_W-1:0] eff_svc,
  output logic [LEN_W-1:0] eff_len
);

  localparam logic [PRE_W-1:0] PRE_CAP = PRE_W'(PRE_MAX);

  logic [1:0]       mode_q;
  logic             ext_q, qpsk_q;
  logic [PRE_W-1:0] pre_q, pre_new;
  logic [SFD_W-1:0] sfd_q;
  logic [SIG_W-1:0] sig_q, sig_new;
  logic [SVC_W-1:0] svc_q;
  logic [LEN_W-1:0] len_q;

  always_comb begin
    pre_new = (in_pre > PRE_CAP) ? PRE_CAP : in_pre;
    sig_new = in_qpsk ? in_sig_q : in_sig_b;
  end

  // Pass-through on the start cycle so the sequencer decides on fresh values.
  always_comb begin
    eff_mode = load ? in_mode : mode_q;
    eff_ext  = load ? in_ext  : ext_q;
    eff_qpsk = load ? in_qpsk : qpsk_q;
    eff_pre  = load ? pre_new : pre_q;
    eff_sfd  = load ? in_sfd  : sfd_q;
    eff_sig  = load ? sig_new : sig_q;
    eff_svc  = load ? in_svc  : svc_q;
    eff_len  = load ? in_len  : len_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ext_q  <= 1'b0;
      qpsk_q <= 1'b0;
      pre_q  <= '0;
      sfd_q  <= '0;
      sig_q  <= '0;
      svc_q  <= '0;
      len_q  <= '0;
    end else if (load) begin
      mode_q <= in_mode;
      ext_q  <= in_ext;
      qpsk_q <= in_qpsk;
      pre_q  <= pre_new;
      sfd_q  <= in_sfd;
      sig_q  <= sig_new;
      svc_q  <= in_svc;
      len_q  <= in_len;
    end
  end

endmodule

// File: rtl/hdr_framer_seq.sv
module hdr_framer_seq
  import hdr_framer_pkg::*;
#(
  parameter int PRE_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic             ext,
  input  logic [PRE_W-1:0] pre_len,
  input  logic [LEN_W-1:0] pay_len,
  input  logic             pl_valid,
  output logic             load,
  output state_e           st,
  output fld_e             fld,
  output logic [3:0]       bit_idx,
  output logic             pl_ready,
  output logic             busy,
  output logic             crc_clr,
  output logic             crc_en,
  output logic             crc_cap
);

  localparam int CNT_W = (PRE_W > LEN_W) ? PRE_W : LEN_W;

  state_e           st_q, st_d;
  fld_e             fld_q, fld_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fld_last;

  assign fld_last = (cnt_q == CNT_W'(fld_len(fld_q) - 1));

  always_comb begin
    st_d    = st_q;
    fld_d   = fld_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    crc_cap = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          load  = 1'b1;
          cnt_d = '0;
          fld_d = FLD_SFD;
          if (ext)
            st_d = (pay_len == '0) ? ST_IDLE : ST_PAY;
          else if (pre_len == '0)
            st_d = ST_HDR;
          else
            st_d = ST_PRE;
        end
      end
      ST_PRE: begin
        if (cnt_q == CNT_W'(pre_len) - 1'b1) begin
          cnt_d = '0;
          st_d  = ST_HDR;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_HDR: begin
        if (fld_last) begin
          cnt_d = '0;
          if (fld_next(mode, fld_q) == FLD_NONE) begin
            crc_cap = (mode != 2'd0);
            st_d    = (pay_len == '0) ? ST_IDLE : ST_PAY;
          end else begin
            fld_d = fld_next(mode, fld_q);
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        if (pl_valid) begin
          if (cnt_q == CNT_W'(pay_len) - 1'b1) begin
            cnt_d = '0;
            st_d  = ST_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      fld_q <= FLD_SFD;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      fld_q <= fld_d;
      cnt_q <= cnt_d;
    end
  end

  assign st       = st_q;
  assign fld      = fld_q;
  assign bit_idx  = cnt_q[3:0];
  assign busy     = (st_q != ST_IDLE);
  assign pl_ready = (st_q == ST_PAY);
  assign crc_clr  = load;
  assign crc_en   = (st_q == ST_HDR) &&
                    ((fld_q == FLD_SIG) || (fld_q == FLD_SVC) || (fld_q == FLD_LEN));

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st_q == ST_IDLE && !(ext && pay_len == '0)) |=> (busy));

endmodule

// File: rtl/hdr_framer_crc.sv
module hdr_framer_crc
  import hdr_framer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  input  logic             cap,
  output logic [CRC_W-1:0] crc_run,
  output logic [CRC_W-1:0] crc_status
);

  logic [CRC_W-1:0] run_q, run_d, stat_q, stat_d;

  always_comb begin
    run_d = run_q;
    if (clr)
      run_d = CRC_INIT;
    else if (en)
      run_d = crc_step(run_q, din);
    stat_d = cap ? run_q : stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= CRC_INIT;
      stat_q <= '0;
    end else begin
      run_q  <= run_d;
      stat_q <= stat_d;
    end
  end

  assign crc_run    = run_q;
  assign crc_status = stat_q;

endmodule

// File: rtl/hdr_framer_out.sv
module hdr_framer_out
  import hdr_framer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  state_e           st,
  input  fld_e             fld,
  input  logic [3:0]       bit_idx,
  input  logic [SFD_W-1:0] sfd,
  input  logic [SIG_W-1:0] sig,
  input  logic [SVC_W-1:0] svc,
  input  logic [LEN_W-1:0] len,
  input  logic [CRC_W-1:0] crc,
  input  logic             qpsk,
  input  logic             pl_valid,
  input  logic             pl_data,
  output logic             hdr_bit,
  output logic             tx_valid,
  output logic             tx_bit,
  output logic             tx_qpsk
);

  logic valid_d, bit_d, qpsk_d;
  logic valid_q, bit_q, qpsk_q;

  always_comb begin
    case (fld)
      FLD_SFD: hdr_bit = sfd[bit_idx];
      FLD_SIG: hdr_bit = sig[bit_idx[2:0]];
      FLD_SVC: hdr_bit = svc[bit_idx[2:0]];
      FLD_LEN: hdr_bit = len[bit_idx];
      FLD_CRC: hdr_bit = crc[bit_idx];
      default: hdr_bit = 1'b0;
    endcase
  end

  always_comb begin
    valid_d = 1'b0;
    bit_d   = 1'b0;
    qpsk_d  = 1'b0;
    case (st)
      ST_PRE: begin
        valid_d = 1'b1;
        bit_d   = 1'b1;
      end
      ST_HDR: begin
        valid_d = 1'b1;
        bit_d   = hdr_bit;
      end
      ST_PAY: begin
        valid_d = pl_valid;
        bit_d   = pl_data;
        qpsk_d  = qpsk;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      bit_q   <= 1'b0;
      qpsk_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      bit_q   <= bit_d;
      qpsk_q  <= qpsk_d;
    end
  end

  assign tx_valid = valid_q;
  assign tx_bit   = bit_q;
  assign tx_qpsk  = qpsk_q;

  // R2
  pre_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PRE) |=> (tx_valid && tx_bit && !tx_qpsk));

  // R7
  hdr_bpsk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HDR) |=> (tx_valid && !tx_qpsk));

endmodule

// File: rtl/hdr_framer.sv
module hdr_framer
  import hdr_framer_pkg::*;
#(
  parameter int PRE_MAX = 256,
  parameter int PRE_W   = $clog2(PRE_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_ext_pre,
  input  logic             cfg_qpsk,
  input  logic [PRE_W-1:0] cfg_pre_len,
  input  logic [15:0]      cfg_sfd,
  input  logic [7:0]       cfg_sig_bpsk,
  input  logic [7:0]       cfg_sig_qpsk,
  input  logic [7:0]       cfg_service,
  input  logic [15:0]      cfg_length,
  input  logic             pl_valid,
  input  logic             pl_data,
  output logic             pl_ready,
  output logic             busy,
  output logic             tx_valid,
  output logic             tx_bit,
  output logic             tx_qpsk,
  output logic [15:0]      crc_status
);

  logic             load;
  logic [1:0]       e_mode;
  logic             e_ext, e_qpsk;
  logic [PRE_W-1:0] e_pre;
  logic [SFD_W-1:0] e_sfd;
  logic [SIG_W-1:0] e_sig;
  logic [SVC_W-1:0] e_svc;
  logic [LEN_W-1:0] e_len;
  state_e           st;
  fld_e             fld;
  logic [3:0]       bit_idx;
  logic             crc_clr, crc_en, crc_cap, hdr_bit;
  logic [CRC_W-1:0] crc_run;

  hdr_framer_cfg #(.PRE_MAX(PRE_MAX), .PRE_W(PRE_W)) i_cfg (
    .clk(clk), .rst_n(rst_n), .load(load),
    .in_mode(cfg_mode), .in_ext(cfg_ext_pre), .in_qpsk(cfg_qpsk),
    .in_pre(cfg_pre_len), .in_sfd(cfg_sfd), .in_sig_b(cfg_sig_bpsk),
    .in_sig_q(cfg_sig_qpsk), .in_svc(cfg_service), .in_len(cfg_length),
    .eff_mode(e_mode), .eff_ext(e_ext), .eff_qpsk(e_qpsk), .eff_pre(e_pre),
    .eff_sfd(e_sfd), .eff_sig(e_sig), .eff_svc(e_svc), .eff_len(e_len)
  );

  hdr_framer_seq #(.PRE_W(PRE_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mode(e_mode), .ext(e_ext), .pre_len(e_pre), .pay_len(e_len),
    .pl_valid(pl_valid), .load(load), .st(st), .fld(fld), .bit_idx(bit_idx),
    .pl_ready(pl_ready), .busy(busy),
    .crc_clr(crc_clr), .crc_en(crc_en), .crc_cap(crc_cap)
  );

  hdr_framer_crc i_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en), .din(hdr_bit),
    .cap(crc_cap), .crc_run(crc_run), .crc_status(crc_status)
  );

  hdr_framer_out i_out (
    .clk(clk), .rst_n(rst_n), .st(st), .fld(fld), .bit_idx(bit_idx),
    .sfd(e_sfd), .sig(e_sig), .svc(e_svc), .len(e_len), .crc(crc_run),
    .qpsk(e_qpsk), .pl_valid(pl_valid), .pl_data(pl_data),
    .hdr_bit(hdr_bit), .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_qpsk(tx_qpsk)
  );

  // R5
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HDR && fld == FLD_CRC) |=> $stable(crc_run));

endmodule

// File: tb/test_hdr_framer.sv
module test_hdr_framer;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, start;
  logic [1:0]  cfg_mode;
  logic        cfg_ext_pre, cfg_qpsk;
  logic [8:0]  cfg_pre_len;
  logic [15:0] cfg_sfd, cfg_length;
  logic [7:0]  cfg_sig_bpsk, cfg_sig_qpsk, cfg_service;
  logic        pl_valid, pl_data;
  logic        pl_ready, busy, tx_valid, tx_bit, tx_qpsk;
  logic [15:0] crc_status;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [9:0]  exp_q[$];   // {tag[7:0], qpsk flag, bit}
  logic [15:0] exp_crc;
  logic        pay[0:63];

  hdr_framer i_hdr_framer (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
    .cfg_ext_pre(cfg_ext_pre), .cfg_qpsk(cfg_qpsk), .cfg_pre_len(cfg_pre_len),
    .cfg_sfd(cfg_sfd), .cfg_sig_bpsk(cfg_sig_bpsk), .cfg_sig_qpsk(cfg_sig_qpsk),
    .cfg_service(cfg_service), .cfg_length(cfg_length),
    .pl_valid(pl_valid), .pl_data(pl_data), .pl_ready(pl_ready), .busy(busy),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_qpsk(tx_qpsk), .crc_status(crc_status)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check1(input int tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
    logic f;
    f = c[15] ^ b;
    crc_bit = {c[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
  endfunction

  task automatic push(input int tag, input logic q, input logic b);
    exp_q.push_back({tag[7:0], q, b});
  endtask

  // Monitor: pops the scoreboard on every emitted bit (R2, R3, R4, R5, R6, R7, R8, R11, R12, R13).
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      logic [9:0] it;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected bit actual %0b expected none", tx_bit);
      end else begin
        it = exp_q.pop_front();
        if (tx_bit !== it[0]) begin
          errors++;
          $display("FAIL R%0d tx_bit actual %0b expected %0b", it[9:2], tx_bit, it[0]);
        end
        if (tx_qpsk !== it[1]) begin
          errors++;
          $display("FAIL R7 tx_qpsk actual %0b expected %0b", tx_qpsk, it[1]);
        end
      end
    end
    // R8: no payload acceptance outside a frame
    if (rst_n && pl_ready && !busy) begin
      errors++;
      $display("FAIL R8 pl_ready actual 1 expected 0");
    end
  end

  task automatic run_frame(input logic [1:0] m, input logic e, input logic q,
                           input logic [8:0] pre, input logic [15:0] sfd,
                           input logic [7:0] sb, input logic [7:0] sq,
                           input logic [7:0] svc, input logic [15:0] len,
                           input int seed, input bit disturb);
    logic [15:0] c;
    logic [7:0]  sg;
    int          pe, sent, cyc, ptag;
    logic [15:0] crc_before;
    crc_before = crc_status;
    pe = (pre > 9'd256) ? 256 : int'(pre);
    sg = q ? sq : sb;
    for (int i = 0; i < 64; i++) pay[i] = (((i * 7 + seed) % 5) < 2);
    cfg_mode = m; cfg_ext_pre = e; cfg_qpsk = q; cfg_pre_len = pre;
    cfg_sfd = sfd; cfg_sig_bpsk = sb; cfg_sig_qpsk = sq;
    cfg_service = svc; cfg_length = len;
    if (!e) begin
      for (int i = 0; i < pe; i++) push((pre > 9'd256) ? 13 : 2, 1'b0, 1'b1);
      for (int i = 0; i < 16; i++) push(3, 1'b0, sfd[i]);
      c = 16'hFFFF;
      if (m == 2'd3) begin
        for (int i = 0; i < 8; i++) begin push(6, 1'b0, sg[i]);  c = crc_bit(c, sg[i]);  end
        for (int i = 0; i < 8; i++) begin push(3, 1'b0, svc[i]); c = crc_bit(c, svc[i]); end
      end
      if (m >= 2'd2)
        for (int i = 0; i < 16; i++) begin push(4, 1'b0, len[i]); c = crc_bit(c, len[i]); end
      if (m != 2'd0) begin
        for (int i = 0; i < 16; i++) push(5, 1'b0, c[i]);
        exp_crc = c;
      end else begin
        exp_crc = crc_before;
      end
    end else begin
      exp_crc = crc_before;
    end
    ptag = e ? 11 : (disturb ? 12 : 8);
    for (int i = 0; i < int'(len); i++) push(ptag, q, pay[i]);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R9: busy rises the cycle after start
    check1(9, "busy after start", {15'd0, busy}, {15'd0, !(e && len == 16'd0)});
    sent = 0; cyc = 0;
    while (sent < int'(len)) begin
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 3) begin
        // R12: new settings and a second start while busy
        cfg_mode = ~m; cfg_ext_pre = ~e; cfg_qpsk = ~q; cfg_pre_len = 9'd1;
        cfg_sfd = ~sfd; cfg_service = ~svc; cfg_length = 16'd50;
        cfg_sig_bpsk = ~sb; cfg_sig_qpsk = ~sq;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      pl_valid = (seed % 2 == 0) ? ((cyc % 3) != 1) : 1'b1;
      pl_data  = pay[sent];
      if (pl_valid && pl_ready) sent++;
    end
    @(negedge clk); pl_valid = 1'b0; start = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    // R3 / R8: nothing left and nothing extra
    check1(3, "pending bits at frame end", 16'(exp_q.size()), 16'd0);
    check1(9, "busy after frame", {15'd0, busy}, 16'd0);
    // R10: status holds latest header CRC
    check1(10, "crc_status", crc_status, exp_crc);
    exp_q.delete();
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; pl_valid = 1'b0; pl_data = 1'b0;
    cfg_mode = 2'd0; cfg_ext_pre = 1'b0; cfg_qpsk = 1'b0; cfg_pre_len = 9'd0;
    cfg_sfd = 16'h0; cfg_sig_bpsk = 8'h0; cfg_sig_qpsk = 8'h0;
    cfg_service = 8'h0; cfg_length = 16'h0; exp_crc = 16'h0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check1(1, "busy in reset", {15'd0, busy}, 16'd0);
    check1(1, "tx_valid in reset", {15'd0, tx_valid}, 16'd0);
    check1(1, "pl_ready in reset", {15'd0, pl_ready}, 16'd0);
    check1(1, "crc_status in reset", crc_status, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check1(1, "busy after reset", {15'd0, busy}, 16'd0);
    check1(1, "tx_valid after reset", {15'd0, tx_valid}, 16'd0);
    // R3 R4 R5 R6: full header, BPSK payload, gaps on payload
    run_frame(2'd3, 1'b0, 1'b0, 9'd16, 16'hF3A0, 8'h0A, 8'h14, 8'h5C, 16'd24, 2, 1'b0);
    // R6 R7: QPSK code and flag
    run_frame(2'd3, 1'b0, 1'b1, 9'd8, 16'h1234, 8'h0A, 8'h14, 8'hC3, 16'd20, 3, 1'b0);
    // R3 R4: length and CRC only
    run_frame(2'd2, 1'b0, 1'b0, 9'd10, 16'hA5C3, 8'h11, 8'h22, 8'h33, 16'd12, 4, 1'b0);
    // R5: mode 1, CRC stays at preset
    run_frame(2'd1, 1'b0, 1'b1, 9'd5, 16'h0F0F, 8'h11, 8'h22, 8'h33, 16'd9, 5, 1'b0);
    // R10 R8: mode 0, no CRC, no payload
    run_frame(2'd0, 1'b0, 1'b0, 9'd3, 16'hBEEF, 8'h11, 8'h22, 8'h33, 16'd0, 6, 1'b0);
    // R11: external framing
    run_frame(2'd3, 1'b1, 1'b1, 9'd40, 16'hBEEF, 8'h11, 8'h22, 8'h33, 16'd15, 7, 1'b0);
    // R13 R12 R9: clamp, settings change and ignored start mid-frame
    run_frame(2'd3, 1'b0, 1'b0, 9'd300, 16'h8001, 8'h3C, 8'hC3, 8'h99, 16'd4, 8, 1'b1);
    // R2: zero sync count
    run_frame(2'd2, 1'b0, 1'b1, 9'd0, 16'h7E81, 8'h01, 8'h02, 8'h03, 16'd5, 9, 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule